// File: doc/BRIEF.md
# Target-Side Status, Interrupt and Byte-Buffer Register Front End

This block is the processor-facing register layer of a serial-bus target controller for I3C or I2C. On one side it has a simple 32-bit register bus with write strobe, read strobe and byte address. On the other side it has an abstract event interface driven by a protocol engine. That interface reports a start condition, a stop condition, an address match, a received byte and a transmit byte taken by the bus. The block records bus events in sticky status flags. It holds interrupt enables that can only be changed through separate set and clear registers, and it presents a masked interrupt view together with a single interrupt line.

Two byte queues sit between the two sides. The receive queue is filled by the bus and drained by byte or half-word reads. The transmit queue is filled by byte writes, each carrying an end-of-message marker, and drained by the bus. Each queue raises a level flag against its own programmable trigger code. The trigger codes sit in a data-control register and change only when a write also carries an unlock bit. The same register flushes the queues and reports their fill levels.

Register offsets: configuration 0x00, status 0x04, enable-set 0x08, enable-clear 0x0C, masked interrupts 0x10, data control 0x14, byte write 0x18, byte write-last 0x1C, byte read 0x20, half-word read 0x24.

Top module: `tgt_regfront`

## Requirements
- R1: Configuration bit 0 (reset 1) lets the target take part in the bus. While it is 0, start, stop, match, received-byte and byte-taken events change no status flag and no queue.
- R2: Status bits 8 (start seen), 9 (address matched) and 10 (stop seen) are sticky. They are set by the corresponding event and cleared only by writing 1 to that bit; writing 0 leaves them unchanged.
- R3: With configuration bit 2 set, start is recorded at the cycle an address match is reported, and stop is recorded only if an address match occurred since the last start or stop.
- R4: Writing 1 to bit 10, 11 or 12 of the enable-set register enables the stop, receive-pending or transmit-space interrupt; writing 1 to that bit of the enable-clear register disables it; zeros have no effect. Enables reset to 0 and read back at the enable-set offset.
- R5: The masked register reads status bits 12:10 ANDed with the enables at bits 12:10, and `irq` is high exactly when any masked bit is 1.
- R6: Status bit 11 (receive pending) is 1 while the receive count meets the receive trigger, and it drops once reads bring the count below it.
- R7: Status bit 12 (transmit space) is 1 while the free transmit space meets the transmit trigger.
- R8: Trigger code 0 means 1, 1 means a quarter of the depth, 2 means half, and 3 means depth-1 entries for receive or an empty queue for transmit.
- R9: Data-control bits 5:4 (transmit trigger, reset 3) and 7:6 (receive trigger, reset 2) change only on a write with bit 3 set.
- R10: Writing 1 to data-control bit 0 flushes the receive queue and bit 1 flushes the transmit queue. Data control reads the transmit count at 20:16, receive count at 28:24, transmit-full at 30 and receive-empty at 31.
- R11: A byte write queues bits 7:0 with end marker bit 8; a write-last always sets the marker. `tx_byte`/`tx_last` show the oldest entry while `tx_avail` is high, a byte-taken event removes it, and writes to a full queue are dropped.
- R12: A byte read returns the oldest received byte in bits 7:0 and removes it. A half-word read returns the oldest in 7:0 and the next in 15:8 and removes up to two. Reads of an empty queue return 0.
- R13: Each queue holds 16 entries, counts run from 0 to 16, and bytes received while the receive queue is full are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops for data reads) |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| ev_start | input | 1 | Bus start or repeated start seen |
| ev_stop | input | 1 | Bus stop seen |
| ev_match | input | 1 | Address of this target matched |
| ev_rx_valid | input | 1 | A byte arrived from the bus |
| ev_rx_byte | input | 8 | Received byte |
| ev_tx_take | input | 1 | Bus consumed the head transmit byte |
| tx_avail | output | 1 | Transmit queue not empty |
| tx_byte | output | 8 | Head transmit byte |
| tx_last | output | 1 | Head byte ends the message |
| irq | output | 1 | Any masked interrupt active |

## Verification
The trigger comparison is driven from a table that walks every receive trigger code with fill levels one below and exactly at its threshold, so an off-by-one or a swapped code shows as a wrong pending flag. Event sequences are replayed with gating off and on, and with the target disabled. Start-without-match, stop-without-match and matched messages separate the gating rule from plain recording. Half-word reads with three bytes queued tell byte order apart from the short final pop. Overfilling both queues exposes the depth limit and the full and empty flags.

// File: rtl/tgt_regfront_pkg.sv
package tgt_regfront_pkg;

    localparam int unsigned ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFF_CFG   = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_STAT  = 8'h04;
    localparam logic [ADDR_W-1:0] OFF_IESET = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_IECLR = 8'h0C;
    localparam logic [ADDR_W-1:0] OFF_IMASK = 8'h10;
    localparam logic [ADDR_W-1:0] OFF_DCTL  = 8'h14;
    localparam logic [ADDR_W-1:0] OFF_WB    = 8'h18;
    localparam logic [ADDR_W-1:0] OFF_WBL   = 8'h1C;
    localparam logic [ADDR_W-1:0] OFF_RB    = 8'h20;
    localparam logic [ADDR_W-1:0] OFF_RH    = 8'h24;

    localparam int unsigned B_EN      = 0;
    localparam int unsigned B_GATE    = 2;
    localparam int unsigned B_START   = 8;
    localparam int unsigned B_MATCH   = 9;
    localparam int unsigned B_STOP    = 10;
    localparam int unsigned B_RXPEND  = 11;
    localparam int unsigned B_TXSPACE = 12;

    localparam int unsigned B_FL_RX   = 0;
    localparam int unsigned B_FL_TX   = 1;
    localparam int unsigned B_UNLOCK  = 3;
    localparam int unsigned B_TXTRIG  = 4;
    localparam int unsigned B_RXTRIG  = 6;
    localparam int unsigned B_TXCNT   = 16;
    localparam int unsigned B_RXCNT   = 24;
    localparam int unsigned B_TXFULL  = 30;
    localparam int unsigned B_RXEMPTY = 31;

    localparam logic [1:0] TXTRIG_RST = 2'd3;
    localparam logic [1:0] RXTRIG_RST = 2'd2;

endpackage

// File: rtl/tgt_byte_fifo.sv
module tgt_byte_fifo #(
    parameter int unsigned W     = 8,
    parameter int unsigned DEPTH = 16,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop1,
    input  logic          pop2,
    output logic [W-1:0]  head0,
    output logic [W-1:0]  head1,
    output logic [CW-1:0] cnt
);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           rd;
        logic [AW-1:0]           wr;
        logic [CW-1:0]           cnt;
    } fifo_st_t;

    fifo_st_t s_d, s_q;
    logic [1:0] npop;
    logic       do_push;

    always_comb begin
        s_d     = s_q;
        do_push = push && (s_q.cnt != CW'(DEPTH));
        if (pop2) begin
            npop = (s_q.cnt >= CW'(2)) ? 2'd2 : s_q.cnt[1:0];
        end else begin
            npop = (pop1 && s_q.cnt != '0) ? 2'd1 : 2'd0;
        end
        if (flush) begin
            s_d.rd  = '0;
            s_d.wr  = '0;
            s_d.cnt = '0;
        end else begin
            if (do_push) begin
                s_d.mem[s_q.wr] = din;
                s_d.wr          = s_q.wr + AW'(1);
            end
            s_d.rd  = s_q.rd + AW'(npop);
            s_d.cnt = s_q.cnt + CW'(do_push) - CW'(npop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign head0 = s_q.mem[s_q.rd];
    assign head1 = s_q.mem[s_q.rd + AW'(1)];
    assign cnt   = s_q.cnt;

endmodule

// File: rtl/tgt_fifo_level.sv
module tgt_fifo_level #(
    parameter int unsigned DEPTH       = 16,
    parameter bit          TOP_IS_FULL = 1'b0,
    localparam int unsigned CW         = $clog2(DEPTH + 1)
) (
    input  logic [1:0]    code,
    input  logic [CW-1:0] level,
    output logic          hit
);

    localparam int unsigned THR_QTR  = (DEPTH / 4 > 0) ? DEPTH / 4 : 1;
    localparam int unsigned THR_HALF = (DEPTH / 2 > 0) ? DEPTH / 2 : 1;

    logic [CW-1:0] thr_top;
    logic [CW-1:0] thr;

    generate
        if (TOP_IS_FULL) begin : g_top_full
            assign thr_top = CW'(DEPTH);
        end else begin : g_top_near
            assign thr_top = CW'(DEPTH - 1);
        end
    endgenerate

    always_comb begin
        case (code)
            2'd0:    thr = CW'(1);
            2'd1:    thr = CW'(THR_QTR);
            2'd2:    thr = CW'(THR_HALF);
            default: thr = thr_top;
        endcase
        hit = (level >= thr);
    end

endmodule

// File: rtl/tgt_regfront.sv
module tgt_regfront
    import tgt_regfront_pkg::*;
#(
    parameter int unsigned DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              ev_start,
    input  logic              ev_stop,
    input  logic              ev_match,
    input  logic              ev_rx_valid,
    input  logic [7:0]        ev_rx_byte,
    input  logic              ev_tx_take,
    output logic              tx_avail,
    output logic [7:0]        tx_byte,
    output logic              tx_last,
    output logic              irq
);

    localparam int unsigned CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic       cfg_en;
        logic       cfg_gate;
        logic       st_start;
        logic       st_match;
        logic       st_stop;
        logic       msg_hit;
        logic [2:0] ien;
        logic [1:0] tx_trig;
        logic [1:0] rx_trig;
    } front_st_t;

    front_st_t s_d, s_q;

    logic          wr_cfg, wr_stat, wr_ieset, wr_ieclr, wr_dctl, wr_wb, wr_wbl;
    logic          rd_rb, rd_rh;
    logic          fl_rx, fl_tx;
    logic          rx_push, tx_push, tx_pop;
    logic [7:0]    rx_h0, rx_h1;
    logic [8:0]    tx_h0, tx_h1;
    logic [8:0]    tx_din;
    logic [CW-1:0] rx_cnt, tx_cnt, tx_space;
    logic          rxpend, txspace;
    logic [2:0]    live_irq;
    logic [31:0]   stat_word;

    assign wr_cfg   = reg_wr && (reg_addr == OFF_CFG);
    assign wr_stat  = reg_wr && (reg_addr == OFF_STAT);
    assign wr_ieset = reg_wr && (reg_addr == OFF_IESET);
    assign wr_ieclr = reg_wr && (reg_addr == OFF_IECLR);
    assign wr_dctl  = reg_wr && (reg_addr == OFF_DCTL);
    assign wr_wb    = reg_wr && (reg_addr == OFF_WB);
    assign wr_wbl   = reg_wr && (reg_addr == OFF_WBL);
    assign rd_rb    = reg_rd && (reg_addr == OFF_RB);
    assign rd_rh    = reg_rd && (reg_addr == OFF_RH);

    assign fl_rx    = wr_dctl && reg_wdata[B_FL_RX];
    assign fl_tx    = wr_dctl && reg_wdata[B_FL_TX];
    assign rx_push  = s_q.cfg_en && ev_rx_valid;
    assign tx_pop   = s_q.cfg_en && ev_tx_take;
    assign tx_push  = wr_wb || wr_wbl;
    assign tx_din   = {wr_wbl | reg_wdata[8], reg_wdata[7:0]};

    // Control and status state
    always_comb begin
        s_d = s_q;
        if (wr_cfg) begin
            s_d.cfg_en   = reg_wdata[B_EN];
            s_d.cfg_gate = reg_wdata[B_GATE];
        end
        if (wr_stat) begin
            if (reg_wdata[B_START]) s_d.st_start = 1'b0;
            if (reg_wdata[B_MATCH]) s_d.st_match = 1'b0;
            if (reg_wdata[B_STOP])  s_d.st_stop  = 1'b0;
        end
        if (wr_ieset) s_d.ien = s_q.ien | reg_wdata[B_TXSPACE:B_STOP];
        if (wr_ieclr) s_d.ien = s_q.ien & ~reg_wdata[B_TXSPACE:B_STOP];
        if (wr_dctl && reg_wdata[B_UNLOCK]) begin
            s_d.tx_trig = reg_wdata[B_TXTRIG +: 2];
            s_d.rx_trig = reg_wdata[B_RXTRIG +: 2];
        end
        if (s_q.cfg_en) begin
            if (ev_start) begin
                s_d.msg_hit = 1'b0;
                if (!s_q.cfg_gate) s_d.st_start = 1'b1;
            end
            if (ev_match) begin
                s_d.msg_hit  = 1'b1;
                s_d.st_match = 1'b1;
                if (s_q.cfg_gate) s_d.st_start = 1'b1;
            end
            if (ev_stop) begin
                if (!s_q.cfg_gate || s_q.msg_hit) s_d.st_stop = 1'b1;
                s_d.msg_hit = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q          <= '0;
            s_q.cfg_en   <= 1'b1;
            s_q.tx_trig  <= TXTRIG_RST;
            s_q.rx_trig  <= RXTRIG_RST;
        end else begin
            s_q <= s_d;
        end
    end

    tgt_byte_fifo #(.W(8), .DEPTH(DEPTH)) u_rxq (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (fl_rx),
        .push  (rx_push),
        .din   (ev_rx_byte),
        .pop1  (rd_rb),
        .pop2  (rd_rh),
        .head0 (rx_h0),
        .head1 (rx_h1),
        .cnt   (rx_cnt)
    );

    tgt_byte_fifo #(.W(9), .DEPTH(DEPTH)) u_txq (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (fl_tx),
        .push  (tx_push),
        .din   (tx_din),
        .pop1  (tx_pop),
        .pop2  (1'b0),
        .head0 (tx_h0),
        .head1 (tx_h1),
        .cnt   (tx_cnt)
    );

    assign tx_space = CW'(DEPTH) - tx_cnt;

    tgt_fifo_level #(.DEPTH(DEPTH), .TOP_IS_FULL(1'b0)) u_rxlvl (
        .code  (s_q.rx_trig),
        .level (rx_cnt),
        .hit   (rxpend)
    );

    tgt_fifo_level #(.DEPTH(DEPTH), .TOP_IS_FULL(1'b1)) u_txlvl (
        .code  (s_q.tx_trig),
        .level (tx_space),
        .hit   (txspace)
    );

    assign live_irq = {txspace, rxpend, s_q.st_stop} & s_q.ien;
    assign irq      = |live_irq;

    assign tx_avail = (tx_cnt != '0);
    assign tx_byte  = tx_h0[7:0];
    assign tx_last  = tx_h0[8];

    always_comb begin
        stat_word            = '0;
        stat_word[B_START]   = s_q.st_start;
        stat_word[B_MATCH]   = s_q.st_match;
        stat_word[B_STOP]    = s_q.st_stop;
        stat_word[B_RXPEND]  = rxpend;
        stat_word[B_TXSPACE] = txspace;
    end

    // Read mux
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFF_CFG: begin
                reg_rdata[B_EN]   = s_q.cfg_en;
                reg_rdata[B_GATE] = s_q.cfg_gate;
            end
            OFF_STAT:  reg_rdata = stat_word;
            OFF_IESET: reg_rdata[B_TXSPACE:B_STOP] = s_q.ien;
            OFF_IMASK: reg_rdata[B_TXSPACE:B_STOP] = live_irq;
            OFF_DCTL: begin
                reg_rdata[B_TXTRIG +: 2] = s_q.tx_trig;
                reg_rdata[B_RXTRIG +: 2] = s_q.rx_trig;
                reg_rdata[B_TXCNT +: 5]  = 5'(tx_cnt);
                reg_rdata[B_RXCNT +: 5]  = 5'(rx_cnt);
                reg_rdata[B_TXFULL]      = (tx_cnt == CW'(DEPTH));
                reg_rdata[B_RXEMPTY]     = (rx_cnt == '0);
            end
            OFF_RB: begin
                if (rx_cnt != '0) reg_rdata[7:0] = rx_h0;
            end
            OFF_RH: begin
                if (rx_cnt != '0)       reg_rdata[7:0]  = rx_h0;
                if (rx_cnt >= CW'(2))   reg_rdata[15:8] = rx_h1;
            end
            default: reg_rdata = '0;
        endcase
    end

    logic unused_tx_h1;
    assign unused_tx_h1 = ^tx_h1;

endmodule

// File: rtl/tgt_regfront_chk.sv
module tgt_regfront_chk #(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          en,
    input logic          gate,
    input logic          msg_hit,
    input logic          st_stop,
    input logic          ev_stop,
    input logic          reg_wr,
    input logic          reg_rd,
    input logic [7:0]    reg_addr,
    input logic [31:0]   reg_wdata,
    input logic [CW-1:0] rx_cnt,
    input logic [CW-1:0] tx_cnt,
    input logic          rxpend,
    input logic          irq,
    input logic [2:0]    ien,
    input logic [3:0]    trig
);

    AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !reg_wr && !reg_rd) |=> ($stable(rx_cnt) && $stable(tx_cnt))); // R1

    AST_GATED_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (en && gate && !msg_hit && ev_stop && !st_stop) |=> !st_stop); // R3

    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ien != 3'b000)); // R5

    AST_RXPEND_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_cnt == '0) |-> !rxpend); // R6

    AST_TRIG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 8'h14 && !reg_wdata[3]) |=> $stable(trig)); // R9

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_cnt <= CW'(DEPTH)) && (tx_cnt <= CW'(DEPTH))); // R13

endmodule

bind tgt_regfront tgt_regfront_chk #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (s_q.cfg_en),
    .gate      (s_q.cfg_gate),
    .msg_hit   (s_q.msg_hit),
    .st_stop   (s_q.st_stop),
    .ev_stop   (ev_stop),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .rx_cnt    (rx_cnt),
    .tx_cnt    (tx_cnt),
    .rxpend    (rxpend),
    .irq       (irq),
    .ien       (s_q.ien),
    .trig      ({s_q.rx_trig, s_q.tx_trig})
);

// File: tb/tb_tgt_regfront.sv
module tb_tgt_regfront;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ev_start = 1'b0, ev_stop = 1'b0, ev_match = 1'b0;
    logic        ev_rx_valid = 1'b0, ev_tx_take = 1'b0;
    logic [7:0]  ev_rx_byte = '0;
    logic        tx_avail, tx_last, irq;
    logic [7:0]  tx_byte;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    localparam logic [7:0] A_CFG = 8'h00, A_STAT = 8'h04, A_SET = 8'h08, A_CLR = 8'h0C,
                           A_MSK = 8'h10, A_DCTL = 8'h14, A_WB = 8'h18, A_WBL = 8'h1C,
                           A_RB = 8'h20, A_RH = 8'h24;

    // {rx trigger code, bytes pushed, expected receive-pending}
    localparam logic [7:0] VEC [8] = '{
        {2'd0, 5'd0,  1'b0}, {2'd0, 5'd1,  1'b1},
        {2'd1, 5'd3,  1'b0}, {2'd1, 5'd4,  1'b1},
        {2'd2, 5'd7,  1'b0}, {2'd2, 5'd8,  1'b1},
        {2'd3, 5'd14, 1'b0}, {2'd3, 5'd15, 1'b1}
    };

    tgt_regfront dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_start(ev_start), .ev_stop(ev_stop),
        .ev_match(ev_match), .ev_rx_valid(ev_rx_valid), .ev_rx_byte(ev_rx_byte),
        .ev_tx_take(ev_tx_take), .tx_avail(tx_avail), .tx_byte(tx_byte), .tx_last(tx_last),
        .irq(irq)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        nchk++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: ev_start = 1'b1;
            1: ev_match = 1'b1;
            2: ev_stop = 1'b1;
            default: ev_tx_take = 1'b1;
        endcase
        @(negedge clk);
        ev_start = 1'b0; ev_match = 1'b0; ev_stop = 1'b0; ev_tx_take = 1'b0;
    endtask

    task automatic rxb(input logic [7:0] b);
        @(negedge clk);
        ev_rx_valid = 1'b1; ev_rx_byte = b;
        @(negedge clk);
        ev_rx_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Reset state
        rd(A_STAT, d); chk("R7 reset status", d, 32'h0000_1000);
        rd(A_DCTL, d); chk("R9 reset dctl", d, 32'h8000_00B0);
        rd(A_CFG, d);  chk("R1 reset cfg", d, 32'h1);
        chk("R5 reset irq", {31'b0, irq}, 32'h0);

        // Trigger table (R8, R6)
        for (int i = 0; i < 8; i++) begin
            wr(A_DCTL, 32'h39 | (32'(VEC[i][7:6]) << 6));
            for (int k = 0; k < int'(VEC[i][5:1]); k++) rxb(8'(k));
            rd(A_STAT, d);
            chk($sformatf("R8 rx code %0d fill %0d", VEC[i][7:6], VEC[i][5:1]),
                32'(d[11]), 32'(VEC[i][0]));
        end
        wr(A_DCTL, 32'hB9);

        // R2 sticky flags
        pulse(0); pulse(1); pulse(2);
        rd(A_STAT, d); chk("R2 all events", d, 32'h1700);
        wr(A_STAT, 32'h0);
        rd(A_STAT, d); chk("R2 zero write", d, 32'h1700);
        wr(A_STAT, 32'h200);
        rd(A_STAT, d); chk("R2 clear matched", d, 32'h1500);
        wr(A_STAT, 32'h700);
        rd(A_STAT, d); chk("R2 clear all", d, 32'h1000);

        // R3 match gating
        wr(A_CFG, 32'h5);
        pulse(0);
        rd(A_STAT, d); chk("R3 start unmatched", d, 32'h1000);
        pulse(2);
        rd(A_STAT, d); chk("R3 stop unmatched", d, 32'h1000);
        pulse(0); pulse(1);
        rd(A_STAT, d); chk("R3 start at match", d, 32'h1300);
        pulse(2);
        rd(A_STAT, d); chk("R3 stop matched", d, 32'h1700);
        wr(A_STAT, 32'h700);
        wr(A_CFG, 32'h1);

        // R1 disabled target
        wr(A_CFG, 32'h0);
        wr(A_WB, 32'hAA);
        pulse(0); pulse(1); pulse(2); rxb(8'h44); pulse(3);
        rd(A_STAT, d); chk("R1 status untouched", d, 32'h0);
        rd(A_DCTL, d); chk("R1 queues untouched", d, 32'h8001_00B0);
        chk("R1 tx head kept", {31'b0, tx_avail}, 32'h1);
        wr(A_CFG, 32'h1);
        wr(A_DCTL, 32'h2);

        // R4 / R5 / R6 interrupts
        wr(A_SET, 32'hC00);
        rd(A_SET, d); chk("R4 set", d, 32'hC00);
        wr(A_SET, 32'h0);
        rd(A_SET, d); chk("R4 zero set", d, 32'hC00);
        wr(A_CLR, 32'h400);
        rd(A_SET, d); chk("R4 clear", d, 32'h800);
        chk("R5 idle irq", {31'b0, irq}, 32'h0);
        wr(A_DCTL, 32'h38);
        rxb(8'h5A);
        rd(A_MSK, d); chk("R5 masked rx", d, 32'h800);
        chk("R5 irq rx", {31'b0, irq}, 32'h1);
        rd(A_RB, d); chk("R12 byte read", d, 32'h5A);
        rd(A_STAT, d); chk("R6 pending cleared", 32'(d[11]), 32'h0);
        chk("R5 irq dropped", {31'b0, irq}, 32'h0);
        wr(A_SET, 32'h1000);
        rd(A_MSK, d); chk("R5 masked tx", d, 32'h1000);
        wr(A_CLR, 32'h1C00);
        chk("R4 all cleared irq", {31'b0, irq}, 32'h0);

        // R9 lock
        wr(A_DCTL, 32'h0);
        rd(A_DCTL, d); chk("R9 locked", d, 32'h8000_0030);
        wr(A_DCTL, 32'hB8);

        // R7 / R8 transmit space
        wr(A_DCTL, 32'hA8);
        for (int k = 0; k < 8; k++) wr(A_WB, 32'(k));
        rd(A_STAT, d); chk("R7 space 8 code 2", 32'(d[12]), 32'h1);
        wr(A_WB, 32'h9);
        rd(A_STAT, d); chk("R7 space 7 code 2", 32'(d[12]), 32'h0);
        wr(A_DCTL, 32'h98);
        rd(A_STAT, d); chk("R8 space 7 code 1", 32'(d[12]), 32'h1);
        wr(A_DCTL, 32'h2);
        rd(A_DCTL, d); chk("R10 tx flush", d, 32'h8000_0090);
        wr(A_DCTL, 32'hB8);

        // R11 transmit path
        wr(A_WB, 32'h055);
        wr(A_WBL, 32'h07E);
        chk("R11 head byte", {23'b0, tx_last, tx_byte}, 32'h055);
        pulse(3);
        chk("R11 last byte", {23'b0, tx_last, tx_byte}, 32'h17E);
        pulse(3);
        chk("R11 drained", {31'b0, tx_avail}, 32'h0);

        // R12 half-word reads
        rxb(8'h11); rxb(8'h22); rxb(8'h33);
        rd(A_RH, d); chk("R12 half pair", d, 32'h2211);
        rd(A_DCTL, d); chk("R12 one left", 32'(d[28:24]), 32'h1);
        rd(A_RH, d); chk("R12 half short", d, 32'h0033);
        rd(A_RB, d); chk("R12 empty read", d, 32'h0);

        // R13 depth
        for (int k = 0; k < 17; k++) rxb(8'(k + 1));
        for (int k = 0; k < 17; k++) wr(A_WB, 32'(k));
        rd(A_DCTL, d);
        chk("R13 rx count", 32'(d[28:24]), 32'd16);
        chk("R13 tx count", 32'(d[20:16]), 32'd16);
        chk("R10 full/empty flags", 32'(d[31:30]), 32'b01);
        rd(A_RB, d); chk("R13 oldest kept", d, 32'h1);
        wr(A_DCTL, 32'h3);
        rd(A_DCTL, d); chk("R10 both flushed", d, 32'h8000_00B0);

        finish_run();
    end

endmodule